// File: doc/BRIEF.md
# SPI Serial Pattern Trigger

This block listens to an SPI bus without driving it and raises a trigger when a chosen 32-bit bit sequence passes on the bus. The serial clock, the active-low chip-select and both data lines are first brought into the system clock domain through synchronizer stages. Serial clock edges are then found from the synchronized samples. On each edge that the programmed SPI mode names as its sampling edge, one bit of the watched data line is shifted into a 32-bit register. The watched line is either the line into the peripheral (SI) or the line out of it (SO).

After every shifted bit the register is compared with a programmed pattern. Bit positions marked in an ignore mask are left out of the comparison. A match produces a single-cycle trigger pulse. Because the comparison runs on every bit, a pattern that starts at any bit offset inside a longer frame is found. A comparison only counts once at least 32 bits have arrived since chip-select went active, so bits from an earlier frame never combine with bits from the current one.

Top module: `spi_pattern_trigger`

## Requirements
- R1: While reset is high and in the cycle after it, `trig_pulse` is 0 and the received-bit count is zero.
- R2: `cfg_mode` values 0 and 3 sample data on the rising serial clock edge. Values 1 and 2 sample on the falling edge. Edges of the other direction shift nothing.
- R3: Bits enter at bit 0 and move toward bit 31, so the first bit sampled of a 32-bit sequence is compared with `cfg_pattern[31]` and the last with `cfg_pattern[0]`.
- R4: A 1 in `cfg_ignore[i]` removes bit position i, with the same numbering as `cfg_pattern`, from the comparison. A 0 keeps it.
- R5: `cfg_src_so` = 0 watches `spi_si`, and `cfg_src_so` = 1 watches `spi_so`. The line that is not selected has no effect.
- R6: No trigger fires until 32 bits have been sampled since `spi_cs_n` went low. `spi_cs_n` high clears the count, so bits split across two chip-select frames never match.
- R7: The comparison is made after every sampled bit once the count is full. Each match gives `trig_pulse` high for exactly one system clock cycle, so consecutive matching bit offsets give one pulse each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Monitored serial clock |
| spi_cs_n | input | 1 | Monitored chip-select, active low |
| spi_si | input | 1 | Monitored data line into the peripheral |
| spi_so | input | 1 | Monitored data line out of the peripheral |
| cfg_pattern | input | 32 | Pattern to match, bit 31 sampled first |
| cfg_ignore | input | 32 | Per-bit mask, 1 = ignore that position |
| cfg_mode | input | 2 | SPI mode 0 to 3 |
| cfg_src_so | input | 1 | Watched line: 0 = SI, 1 = SO |
| trig_pulse | output | 1 | Registered one-cycle trigger on a match |

## Verification
The hardest case to reach is showing that the block samples on the right edge and not only at the right time. With clean bus traffic the data is stable across both clock edges, so sampling on either edge gives the same result. The stimulus therefore drives one data value before the leading edge and the inverted value between the leading and trailing edges. The same waveform then matches the pattern under one mode setting and its complement under the other. Split frames and offset patterns inside longer frames are also driven, to show that the bit count clears on chip-select and that the comparison slides bit by bit.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    SPI_M0 = 2'd0,
    SPI_M1 = 2'd1,
    SPI_M2 = 2'd2,
    SPI_M3 = 2'd3
  } spi_mode_e;

  // Polarity xor phase: equal means the rising edge carries data.
  function automatic logic samples_on_rise(input logic [1:0] mode);
    return ~(mode[1] ^ mode[0]);
  endfunction
endpackage

// File: rtl/spt_sync.sv
module spt_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_r [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_r[g] <= RST_VAL;
        else     stage_r[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stage_r[g] <= RST_VAL;
        else     stage_r[g] <= stage_r[g-1];
      end
    end
  end

  assign q = stage_r[STAGES-1];
endmodule

// File: rtl/spt_edge_sel.sv
module spt_edge_sel
  import spt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_s,
  input  logic       cs_act,
  input  logic [1:0] mode,
  output logic       rise_mode,
  output logic       samp_stb
);
  logic sck_prev;
  logic rose, fell;

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_s;
  end

  assign rose      = sck_s & ~sck_prev;
  assign fell      = ~sck_s & sck_prev;
  assign rise_mode = samples_on_rise(mode);
  assign samp_stb  = cs_act & (rise_mode ? rose : fell);
endmodule

// File: rtl/spt_shift_match.sv
module spt_shift_match #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_act,
  input  logic             samp_stb,
  input  logic             din,
  input  logic [W-1:0]     pattern,
  input  logic [W-1:0]     ignore,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             trig
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0] shreg;
  logic         samp_d;
  logic         hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
      samp_d  <= 1'b0;
    end else begin
      samp_d <= samp_stb;
      if (samp_stb) shreg <= {shreg[W-2:0], din};
      if (!cs_act)                        bit_cnt <= '0;
      else if (samp_stb && bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign hit = ~|((shreg ^ pattern) & ~ignore);

  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= samp_d & (bit_cnt == FULL) & hit;
  end
endmodule

// File: rtl/spi_pattern_trigger.sv
module spi_pattern_trigger #(
  parameter int DATA_W    = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_so,
  input  logic [DATA_W-1:0] cfg_pattern,
  input  logic [DATA_W-1:0] cfg_ignore,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_src_so,
  output logic              trig_pulse
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [3:0]       pins_s;
  logic             sck_s, csn_s, si_s, so_s;
  logic             cs_act, rise_mode, samp_stb;
  logic [CNT_W-1:0] bit_cnt;

  spt_sync #(.W(4), .STAGES(SYNC_STGS), .RST_VAL(4'b0100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_so, spi_cs_n, spi_si, spi_sck}),
    .q   (pins_s)
  );

  assign {so_s, csn_s, si_s, sck_s} = pins_s;
  assign cs_act = ~csn_s;

  spt_edge_sel u_edge (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (sck_s),
    .cs_act    (cs_act),
    .mode      (cfg_mode),
    .rise_mode (rise_mode),
    .samp_stb  (samp_stb)
  );

  spt_shift_match #(.W(DATA_W), .CNT_W(CNT_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .cs_act   (cs_act),
    .samp_stb (samp_stb),
    .din      (cfg_src_so ? so_s : si_s),
    .pattern  (cfg_pattern),
    .ignore   (cfg_ignore),
    .bit_cnt  (bit_cnt),
    .trig     (trig_pulse)
  );
endmodule

// File: rtl/spt_chk.sv
module spt_chk #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             trig,
  input logic             samp,
  input logic             rise,
  input logic             sck_s,
  input logic             cs_act,
  input logic [CNT_W-1:0] cnt
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!trig && cnt == '0));
  // R2
  samp_edge_chk: assert property (@(posedge clk) disable iff (rst) samp |-> (sck_s == rise));
  // R6
  cs_clear_chk: assert property (@(posedge clk) disable iff (rst) !cs_act |=> (cnt == '0));
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(W));
  // R6
  trig_full_chk: assert property (@(posedge clk) disable iff (rst) trig |-> ($past(cnt) == CNT_W'(W)));
  // R7
  trig_after_samp_chk: assert property (@(posedge clk) disable iff (rst) trig |-> $past(samp, 2));
endmodule

bind spi_pattern_trigger spt_chk #(.W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .trig   (trig_pulse),
  .samp   (samp_stb),
  .rise   (rise_mode),
  .sck_s  (sck_s),
  .cs_act (cs_act),
  .cnt    (bit_cnt)
);

// File: tb/test_spi_pattern_trigger.sv
module test_spi_pattern_trigger;
  localparam int H = 3;
  localparam logic [31:0] PAT = 32'hA5C3_0F1E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_so = 1'b0;
  logic [31:0] cfg_pattern = PAT, cfg_ignore = '0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_src_so = 1'b0;
  logic        trig_pulse;

  int checks = 0, failures = 0, pulses = 0, wide = 0;
  logic trig_q = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_pattern_trigger i_spi_pattern_trigger (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_so(spi_so), .cfg_pattern(cfg_pattern),
    .cfg_ignore(cfg_ignore), .cfg_mode(cfg_mode), .cfg_src_so(cfg_src_so),
    .trig_pulse(trig_pulse)
  );

  always_ff @(posedge clk) begin
    trig_q <= trig_pulse;
    if (trig_pulse) pulses <= pulses + 1;
    if (trig_pulse && trig_q) wide <= wide + 1;
  end

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends n bits of word, MSB first. lead_inv/trail_inv invert the data
  // held before the leading and before the trailing clock edge.
  task automatic xfer(input logic [63:0] word, input int n, input bit cpol,
                      input bit on_so, input bit lead_inv, input bit trail_inv);
    spi_sck = cpol;
    waitc(H);
    spi_cs_n = 1'b0;
    waitc(H);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = word[n-1-i] ^ lead_inv;
      if (on_so) begin spi_so = b; spi_si = ~b; end
      else       begin spi_si = b; spi_so = ~b; end
      waitc(H);
      spi_sck = ~cpol;
      waitc(H);
      b = word[n-1-i] ^ trail_inv;
      if (on_so) begin spi_so = b; spi_si = ~b; end
      else       begin spi_si = b; spi_so = ~b; end
      waitc(H);
      spi_sck = cpol;
      waitc(H);
    end
    spi_cs_n = 1'b1;
    waitc(20);
  endtask

  task automatic t_reset;
    waitc(2);
    chk(trig_pulse, 0, "R1 trig during reset");
    rst = 1'b0;
    waitc(3);
    chk(trig_pulse, 0, "R1 trig after reset");
    chk(pulses, 0, "R1 no pulse after reset");
  endtask

  task automatic t_basic;
    int p0;
    cfg_mode = 2'd0; cfg_ignore = '0; cfg_src_so = 0;
    p0 = pulses; xfer({32'b0, PAT}, 32, 0, 0, 0, 0);
    chk(pulses - p0, 1, "R3 exact match mode0");
    p0 = pulses; xfer({32'b0, {<<{PAT}}}, 32, 0, 0, 0, 0);
    chk(pulses - p0, 0, "R3 bit reversed order");
  endtask

  task automatic t_mask;
    int p0;
    cfg_ignore = 32'h0000_FFFF;
    p0 = pulses; xfer({32'b0, PAT ^ 32'h0000_1234}, 32, 0, 0, 0, 0);
    chk(pulses - p0, 1, "R4 ignored bits differ");
    p0 = pulses; xfer({32'b0, PAT ^ 32'h0001_0000}, 32, 0, 0, 0, 0);
    chk(pulses - p0, 0, "R4 kept bit differs");
    cfg_ignore = '0;
  endtask

  task automatic t_source;
    int p0;
    cfg_src_so = 1;
    p0 = pulses; xfer({32'b0, PAT}, 32, 0, 1, 0, 0);
    chk(pulses - p0, 1, "R5 SO watched");
    cfg_src_so = 0;
    p0 = pulses; xfer({32'b0, PAT}, 32, 0, 1, 0, 0);
    chk(pulses - p0, 0, "R5 SO data while SI watched");
  endtask

  task automatic t_count;
    int p0;
    p0 = pulses; xfer({33'b0, PAT[30:0]}, 31, 0, 0, 0, 0);
    chk(pulses - p0, 0, "R6 only 31 bits");
    p0 = pulses;
    xfer({48'b0, PAT[31:16]}, 16, 0, 0, 0, 0);
    xfer({48'b0, PAT[15:0]}, 16, 0, 0, 0, 0);
    chk(pulses - p0, 0, "R6 frame split by chip-select");
  endtask

  task automatic t_modes;
    int p0;
    for (int m = 0; m < 4; m++) begin
      cfg_mode = 2'(m);
      p0 = pulses; xfer({32'b0, PAT}, 32, m[1], 0, 0, 0);
      chk(pulses - p0, 1, $sformatf("R2 match in mode %0d", m));
    end
    // Leading edge carries PAT, trailing edge carries ~PAT.
    cfg_mode = 2'd0;
    p0 = pulses; xfer({32'b0, PAT}, 32, 0, 0, 0, 1);
    chk(pulses - p0, 1, "R2 mode0 samples rising edge");
    cfg_mode = 2'd1;
    p0 = pulses; xfer({32'b0, PAT}, 32, 0, 0, 0, 1);
    chk(pulses - p0, 0, "R2 mode1 ignores rising edge");
    cfg_mode = 2'd2;
    p0 = pulses; xfer({32'b0, PAT}, 32, 1, 0, 0, 1);
    chk(pulses - p0, 1, "R2 mode2 samples falling edge");
    cfg_mode = 2'd3;
    p0 = pulses; xfer({32'b0, PAT}, 32, 1, 0, 1, 0);
    chk(pulses - p0, 1, "R2 mode3 samples rising edge");
    cfg_mode = 2'd0;
  endtask

  task automatic t_slide;
    int p0;
    p0 = pulses; xfer({24'b0, 8'h3C, PAT}, 40, 0, 0, 0, 0);
    chk(pulses - p0, 1, "R7 pattern at offset 8");
    cfg_pattern = '1;
    p0 = pulses; xfer({30'b0, {34{1'b1}}}, 34, 0, 0, 0, 0);
    chk(pulses - p0, 3, "R7 one pulse per matching bit");
    chk(wide, 0, "R7 pulse width one cycle");
    cfg_pattern = PAT;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_mask();
    t_source();
    t_count();
    t_modes();
    t_slide();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule